// File: doc/BRIEF.md
# Latch-Fed Accumulator ALU Stage

This block is the arithmetic section of a small single-address accumulator machine. Two operand latches take words from the internal bus when their write enables are high. Their outputs feed the ALU at all times, and they never drive the bus themselves. The ALU result can be stored in only one place: the accumulator. The accumulator can in turn be placed on the bus when it is read.

A sequencer outside this block sets the latch enables, a one-hot operation select and the accumulator write and read enables. The accumulator sign bit is exported so that the sequencer can decide on branches. Memory, instruction sequencing and the program counter sit outside this block.

Top module: `acc_alu_stage`

## Requirements
- R1: After reset, both operand latches and the accumulator hold zero, `bus_oe` is 0 and `bus_out` is 0.
- R2: At a rising edge with `lat1_we` high, operand latch A takes `bus_in`. With `lat2_we` high, operand latch B takes `bus_in`. A latch whose enable is low keeps its value.
- R3: If `acc_we` is high and `op_sel` is 5'b00001 (load), the accumulator takes latch A at the next edge.
- R4: If `acc_we` is high and `op_sel` is 5'b00010 (add), the accumulator takes A + B modulo 2^W. No carry or overflow flag exists.
- R5: If `acc_we` is high and `op_sel` is 5'b00100 (complement), the accumulator takes the bitwise inverse of A.
- R6: If `acc_we` is high and `op_sel` is 5'b01000 (shift left), the accumulator takes A shifted left by one, with bit 0 filled with 0.
- R7: If `acc_we` is high and `op_sel` is 5'b10000 (shift right), the accumulator takes A shifted right by one arithmetically, so the top bit is copied.
- R8: The accumulator keeps its value when `acc_we` is low. It also keeps its value when `op_sel` is zero or has more than one bit set.
- R9: `acc_sign` always equals the top bit of `acc_q`.
- R10: While `acc_re` is high, `bus_out` equals `acc_q` and `bus_oe` is 1 in the same cycle. While `acc_re` is low, both are 0.
- R11: An accumulator write uses the latch values from before that edge, even when a latch is written at the same edge. A read in the same cycle as an accumulator write shows the old accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | W | Word on the internal bus |
| lat1_we | input | 1 | Write enable of operand latch A |
| lat2_we | input | 1 | Write enable of operand latch B |
| op_sel | input | 5 | One-hot operation select: bit 0 load, bit 1 add, bit 2 complement, bit 3 shift left, bit 4 shift right |
| acc_we | input | 1 | Accumulator write enable |
| acc_re | input | 1 | Accumulator read enable |
| acc_q | output | W | Accumulator value |
| acc_sign | output | 1 | Accumulator sign bit |
| bus_out | output | W | Accumulator drive onto the bus, zero when not read |
| bus_oe | output | 1 | Bus drive valid |

## Verification
Two functions can fall in the same cycle. The first is a latch capture together with an accumulator write that depends on that latch. The second is an accumulator read together with an accumulator write. The bench provokes both by raising `lat1_we` and `acc_we` in one cycle, and by raising `acc_re` and `acc_we` in one cycle. It then judges that the stored result uses the latch contents from before the edge, and that the bus carries the accumulator value from before the write.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int OP_N = 5;
   typedef enum int {
      OP_LOAD = 0,
      OP_ADD  = 1,
      OP_CMP  = 2,
      OP_SHL  = 3,
      OP_SHR  = 4
   } op_idx_e;
endpackage

// File: rtl/acc_alu_reg.sv
// Enabled register with asynchronous active-low reset to zero.
module acc_alu_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/acc_alu_core.sv
// Combinational ALU: one candidate result per operation, selected by AND-OR.
module acc_alu_core #(
   parameter int W = 8,
   parameter int N = acc_alu_pkg::OP_N
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic [N-1:0] sel,
   output logic [W-1:0] res,
   output logic         sel_ok
);
   import acc_alu_pkg::*;

   logic [W-1:0] cand  [N];
   logic [W-1:0] gated [N];

   for (genvar i = 0; i < N; i++) begin : g_op
      if (i == OP_LOAD) begin : g_ld
         assign cand[i] = opa;
      end else if (i == OP_ADD) begin : g_add
         assign cand[i] = opa + opb;
      end else if (i == OP_CMP) begin : g_cmp
         assign cand[i] = ~opa;
      end else if (i == OP_SHL) begin : g_shl
         assign cand[i] = {opa[W-2:0], 1'b0};
      end else begin : g_shr
         assign cand[i] = {opa[W-1], opa[W-1:1]};
      end
      assign gated[i] = sel[i] ? cand[i] : '0;
   end

   always_comb begin
      res = '0;
      for (int k = 0; k < N; k++) res = res | gated[k];
   end

   assign sel_ok = $onehot(sel);
endmodule

// File: rtl/acc_alu_rdport.sv
// Accumulator read-out: a muxed bus drive with a valid flag.
module acc_alu_rdport #(
   parameter int W = 8
) (
   input  logic         re,
   input  logic [W-1:0] acc,
   output logic [W-1:0] drv,
   output logic         oe
);
   assign drv = re ? acc : '0;
   assign oe  = re;
endmodule

// File: rtl/acc_alu_stage.sv
module acc_alu_stage #(
   parameter int W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [W-1:0]              bus_in,
   input  logic                      lat1_we,
   input  logic                      lat2_we,
   input  logic [acc_alu_pkg::OP_N-1:0] op_sel,
   input  logic                      acc_we,
   input  logic                      acc_re,
   output logic [W-1:0]              acc_q,
   output logic                      acc_sign,
   output logic [W-1:0]              bus_out,
   output logic                      bus_oe
);
   localparam int N = acc_alu_pkg::OP_N;

   if (W < 2) begin : g_bad_w
      $error("acc_alu_stage: W must be at least 2");
   end
   if (N != 5) begin : g_bad_n
      $error("acc_alu_stage: operation count must be 5");
   end

   logic [W-1:0] lat1_q, lat2_q, alu_res;
   logic         sel_ok, acc_load;

   acc_alu_reg #(.W(W)) u_lat1 (.clk(clk), .rst_n(rst_n), .we(lat1_we), .d(bus_in), .q(lat1_q));
   acc_alu_reg #(.W(W)) u_lat2 (.clk(clk), .rst_n(rst_n), .we(lat2_we), .d(bus_in), .q(lat2_q));

   acc_alu_core #(.W(W), .N(N)) u_core (
      .opa(lat1_q), .opb(lat2_q), .sel(op_sel), .res(alu_res), .sel_ok(sel_ok)
   );

   assign acc_load = acc_we & sel_ok;

   acc_alu_reg #(.W(W)) u_acc (.clk(clk), .rst_n(rst_n), .we(acc_load), .d(alu_res), .q(acc_q));

   assign acc_sign = acc_q[W-1];

   acc_alu_rdport #(.W(W)) u_rd (.re(acc_re), .acc(acc_q), .drv(bus_out), .oe(bus_oe));
endmodule

// File: rtl/acc_alu_stage_chk.sv
module acc_alu_stage_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] bus_in,
   input logic         lat1_we,
   input logic         lat2_we,
   input logic [4:0]   op_sel,
   input logic         acc_we,
   input logic         acc_re,
   input logic [W-1:0] acc_q,
   input logic [W-1:0] bus_out,
   input logic         bus_oe,
   input logic [W-1:0] lat1_q,
   input logic [W-1:0] lat2_q
);
   a_r2_lat1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      lat1_we |=> lat1_q == $past(bus_in));
   a_r2_lat2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lat2_we |=> $stable(lat2_q));
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && op_sel == 5'b00001) |=> acc_q == $past(lat1_q));
   a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && op_sel == 5'b00010) |=> acc_q == W'($past(lat1_q) + $past(lat2_q)));
   a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && op_sel == 5'b10000) |=> acc_q[W-1] == $past(lat1_q[W-1]));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_we || !$onehot(op_sel)) |=> $stable(acc_q));
   a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_re |-> (bus_out == '0 && !bus_oe));
endmodule

bind acc_alu_stage acc_alu_stage_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .lat1_we(lat1_we), .lat2_we(lat2_we),
   .op_sel(op_sel), .acc_we(acc_we), .acc_re(acc_re), .acc_q(acc_q),
   .bus_out(bus_out), .bus_oe(bus_oe), .lat1_q(lat1_q), .lat2_q(lat2_q)
);

// File: tb/sim_acc_alu_stage.sv
module sim_acc_alu_stage;
   localparam int CLK_P = 10;
   localparam int W = 8;

   logic clk = 0, rst_n = 0;
   logic [W-1:0] bus_in = '0;
   logic lat1_we = 0, lat2_we = 0, acc_we = 0, acc_re = 0;
   logic [4:0] op_sel = '0;
   logic [W-1:0] acc_q, bus_out;
   logic acc_sign, bus_oe;

   int checks = 0, errors = 0;
   logic done = 0;

   typedef struct { logic [W-1:0] acc; string req; } exp_t;
   exp_t sb[$];

   logic [W-1:0] m_l1 = '0, m_l2 = '0, m_acc = '0;

   acc_alu_stage #(.W(W)) u0 (.*);

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: compares accumulator state one time step after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(acc_q == e.acc, e.req, acc_q, e.acc);
            chk(acc_sign == e.acc[W-1], "R9", {7'b0, acc_sign}, {7'b0, e.acc[W-1]});
         end
      end
   end

   // Driver: applies one cycle of stimulus, checks the bus, pushes the expected accumulator.
   task automatic step(input bit l1, input bit l2, input logic [W-1:0] d,
                       input logic [4:0] op, input bit we, input bit re, input string req);
      logic [W-1:0] r;
      exp_t e;
      @(negedge clk);
      lat1_we = l1; lat2_we = l2; bus_in = d; op_sel = op; acc_we = we; acc_re = re;
      #1;
      chk(bus_out == (re ? m_acc : '0), re ? "R10/R11" : "R10", bus_out, re ? m_acc : '0);
      chk(bus_oe == re, "R10", {7'b0, bus_oe}, {7'b0, re});
      case (op)
         5'b00001: r = m_l1;
         5'b00010: r = m_l1 + m_l2;
         5'b00100: r = ~m_l1;
         5'b01000: r = {m_l1[W-2:0], 1'b0};
         5'b10000: r = {m_l1[W-1], m_l1[W-1:1]};
         default:  r = m_acc;
      endcase
      if (we) m_acc = r;
      if (l1) m_l1 = d;
      if (l2) m_l2 = d;
      e.acc = m_acc; e.req = req;
      sb.push_back(e);
   endtask

   initial begin
      #(CLK_P*5000);
      chk(0, "watchdog", '0, '0);
      done = 1;
   end

   initial begin
      #(CLK_P*2 + 2);
      // R1 reset state
      chk(acc_q == '0, "R1", acc_q, '0);
      chk(bus_oe == 0 && bus_out == '0, "R1", bus_out, '0);
      @(negedge clk); rst_n = 1;
      step(0,0,8'h00,5'b00001,1,0,"R1");            // load of reset latch A gives 0
      step(1,0,8'h5A,5'b00000,0,0,"R2");
      step(0,1,8'h33,5'b00000,0,0,"R2");
      step(0,0,8'hFF,5'b00001,1,1,"R3");            // bus ignored, A stays 5A
      step(0,0,8'h00,5'b00010,1,1,"R4");            // 5A+33=8D
      step(1,1,8'hC8,5'b00000,0,1,"R8");
      step(0,0,8'h00,5'b00010,1,0,"R4");            // C8+C8 wraps to 90
      step(1,0,8'h96,5'b00000,0,0,"R2");
      step(0,0,8'h00,5'b00100,1,1,"R5");            // ~96=69
      step(0,0,8'h00,5'b01000,1,0,"R6");            // 2C
      step(0,0,8'h00,5'b10000,1,1,"R7");            // CB
      step(1,0,8'h41,5'b00000,0,0,"R2");
      step(0,0,8'h00,5'b10000,1,0,"R7");            // 20
      step(0,0,8'h00,5'b01000,1,0,"R6");            // 82
      step(0,0,8'h00,5'b00011,1,1,"R8");            // multi-hot: hold
      step(0,0,8'h00,5'b00000,1,0,"R8");            // zero select: hold
      step(0,0,8'h00,5'b00001,0,0,"R8");            // write low: hold
      step(1,0,8'h7E,5'b00001,1,1,"R11");           // loads old A (41), latch takes 7E
      step(0,0,8'h00,5'b00001,1,1,"R11");           // now 7E, bus shows 41
      step(0,0,8'h00,5'b00000,0,1,"R10");
      step(1,1,8'h80,5'b00000,0,0,"R2");
      step(0,0,8'h00,5'b00010,1,0,"R4");            // 80+80 wraps to 00
      step(0,0,8'h00,5'b00000,0,0,"R8");
      @(negedge clk); @(negedge clk);
      done = 1;
   end

   initial begin
      wait (done);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule